// File: doc/BRIEF.md
# CRC-32 Word Checksum Accelerator

This block sits on a simple register bus and keeps a 32-bit running checksum. Software clears the checksum by writing the reload bit, then writes data words one after another to the data register. Each write folds the whole word into the checksum in one clock cycle. Reading the data register returns the current checksum and leaves it unchanged. A typical use is an image integrity check at boot. The checksum of an image is stored as a word right after the image, and the check passes when the register reads zero after that stored word has also been fed in.

The checksum uses the generator 0x04C11DB7. Each word enters most significant bit first, with no reflection on input or output and no final inversion. The reload value comes from a programmable register, which powers up as all ones. An 8-bit scratch register is also provided; it has no link to the checksum.

Top module: `crcw_accel`

## Requirements
- R1: After reset the data register (offset 0) reads 0xFFFFFFFF, the reload-value register (offset 4) reads 0xFFFFFFFF, the scratch register (offset 1) reads 0 and the control register (offset 2) reads 0.
- R2: A write to offset 0 updates the checksum by first XOR-ing the word into it, then running 32 shift steps, most significant bit first, with polynomial 0x04C11DB7. From 0xFFFFFFFF, word 0x0000000A gives 0xE88E0BAD and word 0xFFFFFFFF gives 0x00000000.
- R3: A read of offset 0 returns the checksum and does not change it, however many reads are made.
- R4: If a sequence of words is followed by the checksum computed over that sequence, offset 0 then reads 0x00000000.
- R5: Writing a word with bit 0 set to offset 2 loads the checksum from the reload-value register. Offset 2 always reads 0, because the bit clears itself and the other bits are fixed at zero.
- R6: A write to offset 4 sets the value used by later reloads and does not change the current checksum.
- R7: Offset 1 holds the low 8 bits of the last word written to it. It reads back with bits 31:8 as zero, and a write to it leaves the checksum unchanged.
- R8: Offsets 3, 5, 6 and 7 read 0. Writes to them change no register.
- R9: A write to offset 2 with bit 0 clear leaves the checksum unchanged.
- R10: Data writes in consecutive cycles each fold one word. A read of offset 0 in the cycle after a write returns the updated checksum.
- R11: bus_rdata is 0 whenever no read is being made (bus_valid low, or bus_write high).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_valid | input | 1 | Bus access in this cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 3 | Word offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the read |

## Verification
The bench builds the block with its default parameters: a 32-bit checksum, generator 0x04C11DB7, a reload value of all ones at power-up, an 8-bit scratch register and a 3-bit word address. With a 3-bit address every offset can be reached, including the hole at 3 and the unmapped offsets 5 to 7, so each access that should be ignored is actually made. The known single-word results, the zero residue after a stored checksum, and the reload from a reprogrammed value are all checked against a bitwise model that the bench holds itself.

// File: rtl/crcw_pkg.sv
package crcw_pkg;

  parameter int CRC_W  = 32;
  parameter int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] OFS_DATA    = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_SCRATCH = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] OFS_CTRL    = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] OFS_INIT    = ADDR_W'(4);

  localparam int CTRL_RELOAD_BIT = 0;

  typedef struct packed {
    logic wr_data;
    logic wr_scratch;
    logic wr_ctrl;
    logic wr_init;
    logic rd;
  } crcw_sel_t;

endpackage

// File: rtl/crcw_rst_sync.sv
module crcw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/crcw_fold.sv
module crcw_fold #(
  parameter int          W    = 32,
  parameter logic [W-1:0] POLY = 32'h04C11DB7
) (
  input  logic [W-1:0] crc_in,
  input  logic [W-1:0] word_in,
  output logic [W-1:0] crc_out
);

  logic [W-1:0] stage [W+1];

  assign stage[0] = crc_in ^ word_in;

  for (genvar i = 0; i < W; i++) begin : g_shift
    logic [W-1:0] shifted;
    assign shifted      = {stage[i][W-2:0], 1'b0};
    assign stage[i+1]   = stage[i][W-1] ? (shifted ^ POLY) : shifted;
  end

  assign crc_out = stage[W];

endmodule

// File: rtl/crcw_decode.sv
module crcw_decode
  import crcw_pkg::*;
(
  input  logic              valid,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  output crcw_sel_t         sel
);

  logic wr_en;

  always_comb begin
    wr_en          = valid & write;
    sel            = '0;
    sel.rd         = valid & ~write;
    sel.wr_data    = wr_en & (addr == OFS_DATA);
    sel.wr_scratch = wr_en & (addr == OFS_SCRATCH);
    sel.wr_ctrl    = wr_en & (addr == OFS_CTRL);
    sel.wr_init    = wr_en & (addr == OFS_INIT);
  end

endmodule

// File: rtl/crcw_accel.sv
module crcw_accel
  import crcw_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY       = 32'h04C11DB7,
  parameter logic [CRC_W-1:0] INIT_RESET = 32'hFFFFFFFF,
  parameter int               SCRATCH_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CRC_W-1:0]  bus_wdata,
  output logic [CRC_W-1:0]  bus_rdata
);

  localparam int PAD_W = CRC_W - SCRATCH_W;

  logic                 srst_n;
  crcw_sel_t            sel;
  logic [CRC_W-1:0]     crc_q, crc_d, crc_folded;
  logic [CRC_W-1:0]     init_q, init_d;
  logic [SCRATCH_W-1:0] scratch_q, scratch_d;
  logic                 crc_en, init_en, scratch_en;
  logic                 reload_req;

  crcw_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  crcw_decode u_decode (
    .valid (bus_valid),
    .write (bus_write),
    .addr  (bus_addr),
    .sel   (sel)
  );

  crcw_fold #(.W(CRC_W), .POLY(POLY)) u_fold (
    .crc_in  (crc_q),
    .word_in (bus_wdata),
    .crc_out (crc_folded)
  );

  // next state; a reload request wins over a data fold
  always_comb begin
    reload_req = sel.wr_ctrl & bus_wdata[CTRL_RELOAD_BIT];
    crc_en     = reload_req | sel.wr_data;
    if (reload_req) begin
      crc_d = init_q;
    end else begin
      crc_d = crc_folded;
    end
    init_en    = sel.wr_init;
    init_d     = bus_wdata;
    scratch_en = sel.wr_scratch;
    scratch_d  = bus_wdata[SCRATCH_W-1:0];
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      crc_q     <= INIT_RESET;
      init_q    <= INIT_RESET;
      scratch_q <= '0;
    end else begin
      if (crc_en) begin
        crc_q <= crc_d;
      end
      if (init_en) begin
        init_q <= init_d;
      end
      if (scratch_en) begin
        scratch_q <= scratch_d;
      end
    end
  end

  // read mux; control and unmapped offsets return zero
  always_comb begin
    bus_rdata = '0;
    if (sel.rd) begin
      case (bus_addr)
        OFS_DATA:    bus_rdata = crc_q;
        OFS_SCRATCH: bus_rdata = {{PAD_W{1'b0}}, scratch_q};
        OFS_INIT:    bus_rdata = init_q;
        default:     bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/crcw_accel_chk.sv
module crcw_accel_chk
  import crcw_pkg::*;
(
  input logic              clk,
  input logic              srst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [CRC_W-1:0]  bus_wdata,
  input logic [CRC_W-1:0]  bus_rdata,
  input logic [CRC_W-1:0]  crc_q,
  input logic [CRC_W-1:0]  init_q
);

  // R5
  ctrl_reads_zero_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_valid && !bus_write && bus_addr == OFS_CTRL) |-> bus_rdata == '0);

  // R5
  reload_from_init_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_valid && bus_write && bus_addr == OFS_CTRL && bus_wdata[CTRL_RELOAD_BIT])
    |=> crc_q == $past(init_q));

  // R3
  read_keeps_crc_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_valid && !bus_write) |=> $stable(crc_q));

  // R4
  self_residue_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_valid && bus_write && bus_addr == OFS_DATA && bus_wdata == crc_q)
    |=> crc_q == '0);

  // R7
  scratch_upper_zero_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_valid && !bus_write && bus_addr == OFS_SCRATCH) |-> bus_rdata[CRC_W-1:8] == '0);

  // R8
  hole_reads_zero_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_valid && !bus_write && bus_addr == ADDR_W'(3)) |-> bus_rdata == '0);

  // R9
  ctrl_noreload_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_valid && bus_write && bus_addr == OFS_CTRL && !bus_wdata[CTRL_RELOAD_BIT])
    |=> $stable(crc_q));

  // R6
  init_write_keeps_crc_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_valid && bus_write && bus_addr == OFS_INIT) |=> $stable(crc_q));

  // R11
  idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !(bus_valid && !bus_write) |-> bus_rdata == '0);

endmodule

bind crcw_accel crcw_accel_chk u_chk (
  .clk       (clk),
  .srst_n    (srst_n),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .crc_q     (crc_q),
  .init_q    (init_q)
);

// File: tb/crcw_accel_test.sv
`timescale 1ns/1ps
module crcw_accel_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  crcw_accel uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
  );

  function automatic logic [31:0] model_fold(logic [31:0] c, logic [31:0] w);
    logic [31:0] r;
    r = c;
    for (int b = 31; b >= 0; b--) begin
      logic fb;
      fb = r[31] ^ w[b];
      r  = {r[30:0], 1'b0} ^ (fb ? 32'h04C11DB7 : 32'h0);
    end
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic reload();
    wr(3'd2, 32'h1);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(3'd0, v); check("R1 data", v, 32'hFFFFFFFF);
    rd(3'd4, v); check("R1 init", v, 32'hFFFFFFFF);
    rd(3'd1, v); check("R1 scratch", v, 32'h0);
    rd(3'd2, v); check("R1 ctrl", v, 32'h0);
  endtask

  task automatic t_known();
    logic [31:0] v;
    reload();
    wr(3'd0, 32'h0000000A);
    rd(3'd0, v); check("R2 word 0A", v, 32'hE88E0BAD);
    reload();
    wr(3'd0, 32'hFFFFFFFF);
    rd(3'd0, v); check("R2 word FFFFFFFF", v, 32'h0);
    reload();
    rd(3'd0, v); check("R5 reload empty", v, 32'hFFFFFFFF);
  endtask

  task automatic t_read_stable();
    logic [31:0] v;
    reload();
    wr(3'd0, 32'h13579BDF);
    for (int k = 0; k < 4; k++) begin
      rd(3'd0, v); check("R3 repeated read", v, model_fold(32'hFFFFFFFF, 32'h13579BDF));
    end
  endtask

  task automatic t_stream();
    logic [31:0] v, exp, w;
    reload();
    exp = 32'hFFFFFFFF;
    w = 32'h1BADF00D;
    // R10 back-to-back writes, one per cycle
    @(negedge clk);
    for (int k = 0; k < 6; k++) begin
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 3'd0; bus_wdata = w;
      exp = model_fold(exp, w);
      w = {w[30:0], w[31] ^ w[21] ^ w[1] ^ w[0]};
      @(negedge clk);
    end
    bus_write = 1'b0;
    rd(3'd0, v); check("R10 consecutive folds", v, exp);
    wr(3'd0, exp);
    rd(3'd0, v); check("R4 residue zero", v, 32'h0);
    reload();
    wr(3'd0, 32'h0000000A);
    wr(3'd0, 32'hE88E0BAD);
    rd(3'd0, v); check("R4 residue single word", v, 32'h0);
  endtask

  task automatic t_ctrl();
    logic [31:0] v, exp;
    reload();
    wr(3'd0, 32'hCAFEBABE);
    exp = model_fold(32'hFFFFFFFF, 32'hCAFEBABE);
    wr(3'd2, 32'hFFFFFFFE);
    rd(3'd0, v); check("R9 ctrl bit0 clear", v, exp);
    rd(3'd2, v); check("R5 ctrl reads zero", v, 32'h0);
    wr(3'd2, 32'h00000001);
    rd(3'd2, v); check("R5 ctrl self-clear", v, 32'h0);
    rd(3'd0, v); check("R5 reload", v, 32'hFFFFFFFF);
  endtask

  task automatic t_init();
    logic [31:0] v, exp;
    reload();
    wr(3'd0, 32'h00000055);
    exp = model_fold(32'hFFFFFFFF, 32'h00000055);
    wr(3'd4, 32'h12345678);
    rd(3'd0, v); check("R6 init write keeps crc", v, exp);
    rd(3'd4, v); check("R6 init readback", v, 32'h12345678);
    reload();
    rd(3'd0, v); check("R6 reload new init", v, 32'h12345678);
    wr(3'd0, 32'hA5A5A5A5);
    rd(3'd0, v); check("R6 fold from new init", v, model_fold(32'h12345678, 32'hA5A5A5A5));
    wr(3'd4, 32'hFFFFFFFF);
    reload();
  endtask

  task automatic t_scratch();
    logic [31:0] v;
    wr(3'd0, 32'h0000000A);
    wr(3'd1, 32'hABCDEF5A);
    rd(3'd1, v); check("R7 scratch readback", v, 32'h0000005A);
    rd(3'd0, v); check("R7 scratch no crc effect", v, 32'hE88E0BAD);
  endtask

  task automatic t_holes();
    logic [31:0] v;
    reload();
    wr(3'd0, 32'h0000000A);
    wr(3'd1, 32'h000000C3);
    foreach (v[k]) begin end
    for (int a = 3; a < 8; a++) begin
      if (a != 4) wr(a[2:0], 32'hFFFFFFFF);
    end
    for (int a = 3; a < 8; a++) begin
      if (a != 4) begin
        rd(a[2:0], v); check("R8 unmapped reads zero", v, 32'h0);
      end
    end
    rd(3'd0, v); check("R8 crc untouched", v, 32'hE88E0BAD);
    rd(3'd1, v); check("R8 scratch untouched", v, 32'h000000C3);
    rd(3'd4, v); check("R8 init untouched", v, 32'hFFFFFFFF);
  endtask

  task automatic t_idle();
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; bus_addr = 3'd0;
    #1 check("R11 rdata idle", bus_rdata, 32'h0);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 3'd4; bus_wdata = 32'hFFFFFFFF;
    #1 check("R11 rdata during write", bus_rdata, 32'h0);
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_known();
    t_read_stable();
    t_stream();
    t_ctrl();
    t_init();
    t_scratch();
    t_holes();
    t_idle();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule